// File: doc/BRIEF.md
# Programmable Skew Tap Selector

This block delays one clock output pair against a reference clock by a selectable whole number of time units. A time unit is one period of a fast sampling clock. The reference, already sampled in that clock domain, feeds a tapped shift register, and a multiplexer picks one tap to drive the registered output pair. Both outputs of the pair always carry the same delay.

Three control pins choose the setting. Each pin takes one of three levels, and a pin that is left open reads as the middle level. Together the pins form 27 codes. Sixteen of them select signed offsets from -8 to +7 time units around a zero-skew centre. One selects a minimum-latency pass-through. One selects an inverted copy at the centre delay. The remaining codes fall back to zero skew. A new code takes effect only on a rising edge of the reference, so the output never changes shape partway through a reference cycle.

Top module: `skew_tap_selector`

## Requirements
- R1: Each control pin is a 2-bit code: 2'b00 is low, 2'b01 is mid, 2'b10 is high, and 2'b11 means not driven. A not-driven pin behaves exactly like mid.
- R2: Pin levels map to weights low=0, mid=1, high=2. The code index is 9*w(skew_sel2) + 3*w(skew_sel1) + w(skew_sel0). Indices 5 to 20 select delay mode with signed offset (index - 13).
- R3: With all pins mid or open (index 13, offset 0), a reference value sampled at clock edge e appears on the outputs just after edge e+9.
- R4: In delay mode with offset k (-8..+7), a reference value sampled at edge e appears on the outputs just after edge e+9+k.
- R5: Index 21 selects pass-through: a reference value sampled at edge e appears on the outputs just after edge e.
- R6: Index 22 selects inverted output: the inverse of a reference value sampled at edge e appears just after edge e+9.
- R7: Indices 0 to 4 and 23 to 26 select zero skew, with the same timing as R3.
- R8: The decoded code is adopted only at an edge where the sampled reference is 1 and the previous sample was 0. The output at that edge still uses the old setting. Control changes at all other edges have no effect on the outputs.
- R9: All outputs of the pair are equal on every cycle.
- R10: While reset is asserted, the outputs are 0 and the active setting is zero-skew delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Sampling clock; one period is one time unit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Reference clock sampled in the clk_fast domain |
| skew_sel0 | input | 2 | Control pin 0 code (weight 1) |
| skew_sel1 | input | 2 | Control pin 1 code (weight 3) |
| skew_sel2 | input | 2 | Control pin 2 code (weight 9) |
| pair_q | output | NUM_OUT | Delayed output pair |

## Verification
On every cycle, the assertions check four things: the outputs of the pair are identical, the active setting stays put unless a reference rise is sampled, pass-through mode copies the previous sample, and reset forces the outputs low. Only the bench scenarios can show the tap timing for each offset, the code-to-offset map with its undriven-as-mid rule, the inverted and fallback codes, and that a control change made while the reference holds steady waits for the next rise. The bench shows these by comparing every output cycle against a model built from a history of reference samples.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_OPEN = 2'b11
  } level_e;

  typedef enum logic [1:0] {
    MODE_DELAY = 2'b00,
    MODE_PASS  = 2'b01,
    MODE_INV   = 2'b10
  } mode_e;

  localparam int N_PINS      = 3;
  localparam int RADIX       = 3;
  localparam int CODE_SPAN   = RADIX ** N_PINS;
  localparam int CENTRE_CODE = (CODE_SPAN - 1) / 2;

endpackage

// File: rtl/tsel_level_norm.sv
module tsel_level_norm (
  input  logic [1:0] pin_code,
  output logic [1:0] weight
);
  import tsel_pkg::*;

  always_comb begin
    case (level_e'(pin_code))
      LVL_LOW:  weight = 2'd0;
      LVL_HIGH: weight = 2'd2;
      default:  weight = 2'd1;   // mid and open
    endcase
  end

endmodule

// File: rtl/tsel_tap_decode.sv
module tsel_tap_decode #(
  parameter int NUM_TAPS = 16,
  localparam int TAP_W = $clog2(NUM_TAPS)
) (
  input  logic [2*tsel_pkg::N_PINS-1:0] ctl_bus,
  output tsel_pkg::mode_e               dec_mode,
  output logic [TAP_W-1:0]              dec_tap
);
  import tsel_pkg::*;

  localparam int CENTRE     = NUM_TAPS / 2;
  localparam int FIRST_CODE = CENTRE_CODE - CENTRE;
  localparam int PASS_CODE  = FIRST_CODE + NUM_TAPS;
  localparam int INV_CODE   = PASS_CODE + 1;

  logic [1:0] pin_w [N_PINS];

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    tsel_level_norm u_norm (
      .pin_code (ctl_bus[2*p +: 2]),
      .weight   (pin_w[p])
    );
  end

  always_comb begin
    int idx;
    idx = 0;
    for (int p = N_PINS - 1; p >= 0; p--) begin
      idx = idx * RADIX + int'(pin_w[p]);
    end
    dec_mode = MODE_DELAY;
    dec_tap  = TAP_W'(CENTRE);
    if (idx >= FIRST_CODE && idx < PASS_CODE) begin
      dec_tap = TAP_W'(idx - FIRST_CODE);
    end else if (idx == PASS_CODE) begin
      dec_mode = MODE_PASS;
    end else if (idx == INV_CODE) begin
      dec_mode = MODE_INV;
    end
  end

endmodule

// File: rtl/tsel_delay_line.sv
module tsel_delay_line #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [LEN-1:0] taps
);

  logic [LEN-1:0] taps_d;

  always_comb begin
    taps_d = {taps[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= taps_d;
  end

endmodule

// File: rtl/tsel_out_stage.sv
module tsel_out_stage #(
  parameter int NUM_TAPS = 16,
  parameter int NUM_OUT  = 2,
  localparam int TAP_W = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                ref_in,
  input  tsel_pkg::mode_e     mode,
  input  logic [TAP_W-1:0]    tap,
  output logic [NUM_OUT-1:0]  q
);
  import tsel_pkg::*;

  localparam int CENTRE = NUM_TAPS / 2;

  logic pick;

  always_comb begin
    case (mode)
      MODE_DELAY: pick = taps[tap];
      MODE_PASS:  pick = ref_in;
      MODE_INV:   pick = ~taps[CENTRE];
      default:    pick = taps[CENTRE];
    endcase
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[o] <= 1'b0;
      else        q[o] <= pick;
    end
  end

endmodule

// File: rtl/skew_tap_selector.sv
module skew_tap_selector #(
  parameter int NUM_TAPS = 16,
  parameter int NUM_OUT  = 2
) (
  input  logic               clk_fast,
  input  logic               rst_n,
  input  logic               ref_in,
  input  logic [1:0]         skew_sel0,
  input  logic [1:0]         skew_sel1,
  input  logic [1:0]         skew_sel2,
  output logic [NUM_OUT-1:0] pair_q
);
  import tsel_pkg::*;

  localparam int TAP_W  = $clog2(NUM_TAPS);
  localparam int CENTRE = NUM_TAPS / 2;

  logic [1:0]          rst_sync;
  logic                rst_core_n;
  logic [NUM_TAPS-1:0] taps;
  logic                ref_rise;
  mode_e               dec_mode, act_mode, act_mode_d;
  logic [TAP_W-1:0]    dec_tap, act_tap, act_tap_d;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  tsel_tap_decode #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .ctl_bus  ({skew_sel2, skew_sel1, skew_sel0}),
    .dec_mode (dec_mode),
    .dec_tap  (dec_tap)
  );

  tsel_delay_line #(.LEN(NUM_TAPS)) u_line (
    .clk   (clk_fast),
    .rst_n (rst_core_n),
    .din   (ref_in),
    .taps  (taps)
  );

  assign ref_rise = ref_in & ~taps[0];

  always_comb begin
    act_mode_d = act_mode;
    act_tap_d  = act_tap;
    if (ref_rise) begin
      act_mode_d = dec_mode;
      act_tap_d  = dec_tap;
    end
  end

  always_ff @(posedge clk_fast or negedge rst_core_n) begin
    if (!rst_core_n) begin
      act_mode <= MODE_DELAY;
      act_tap  <= TAP_W'(CENTRE);
    end else begin
      act_mode <= act_mode_d;
      act_tap  <= act_tap_d;
    end
  end

  tsel_out_stage #(.NUM_TAPS(NUM_TAPS), .NUM_OUT(NUM_OUT)) u_out (
    .clk    (clk_fast),
    .rst_n  (rst_core_n),
    .taps   (taps),
    .ref_in (ref_in),
    .mode   (act_mode),
    .tap    (act_tap),
    .q      (pair_q)
  );

endmodule

// File: rtl/skew_tap_selector_chk.sv
module skew_tap_selector_chk #(
  parameter int NUM_OUT = 2,
  parameter int TAP_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_in,
  input logic               rise,
  input tsel_pkg::mode_e    act_mode,
  input logic [TAP_W-1:0]   act_tap,
  input logic [NUM_OUT-1:0] pair_q
);
  import tsel_pkg::*;

  // R9
  pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q == {NUM_OUT{pair_q[0]}});

  // R8
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(act_tap) && $stable(act_mode)));

  // R5
  pass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_PASS) |=> (pair_q[0] == $past(ref_in)));

  // R10
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |-> (pair_q == '0));

endmodule

bind skew_tap_selector skew_tap_selector_chk #(
  .NUM_OUT (NUM_OUT),
  .TAP_W   (TAP_W)
) u_chk (
  .clk      (clk_fast),
  .rst_n    (rst_core_n),
  .ref_in   (ref_in),
  .rise     (ref_rise),
  .act_mode (act_mode),
  .act_tap  (act_tap),
  .pair_q   (pair_q)
);

// File: tb/skew_tap_selector_test.sv
module skew_tap_selector_test;

  localparam int NUM_OUT = 2;
  localparam int HIST    = 20;

  logic               clk;
  logic               rst_n;
  logic               ref_in;
  logic [1:0]         s0, s1, s2;
  logic [NUM_OUT-1:0] pair_q;

  int n_checks = 0;
  int n_fails  = 0;

  logic hist [HIST];
  int   m_mode;   // 0 delay, 1 pass, 2 inverted
  int   m_tap;

  skew_tap_selector #(.NUM_TAPS(16), .NUM_OUT(NUM_OUT)) uut (
    .clk_fast  (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .skew_sel0 (s0),
    .skew_sel1 (s1),
    .skew_sel2 (s2),
    .pair_q    (pair_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lvl_w(input logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
  endfunction

  // returns mode*100 + tap
  function automatic int ref_decode(input logic [1:0] c2, input logic [1:0] c1,
                                    input logic [1:0] c0);
    int idx;
    idx = 9 * lvl_w(c2) + 3 * lvl_w(c1) + lvl_w(c0);
    if (idx >= 5 && idx <= 20) return idx - 5;
    if (idx == 21) return 100 + 8;
    if (idx == 22) return 200 + 8;
    return 8;
  endfunction

  function automatic logic expect_out();
    if (m_mode == 1) return hist[0];
    if (m_mode == 2) return ~hist[9];
    return hist[m_tap + 1];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] c2, input logic [1:0] c1,
                      input logic [1:0] c0, input string tag);
    logic e;
    int   d;
    @(negedge clk);
    ref_in = r; s2 = c2; s1 = c1; s0 = c0;
    @(posedge clk);
    #1;
    for (int i = HIST - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = r;
    e = expect_out();
    check(tag, pair_q[0], e);
    check("R9", pair_q[1], pair_q[0]);
    if (hist[0] && !hist[1]) begin
      d = ref_decode(c2, c1, c0);
      m_mode = d / 100;
      m_tap  = d % 100;
    end
  endtask

  task automatic wave(input logic [1:0] c2, input logic [1:0] c1,
                      input logic [1:0] c0, input int half, input int cycles,
                      input string tag);
    for (int i = 0; i < cycles; i++) step(((i / half) % 2) == 1, c2, c1, c0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    rst_n = 1'b0; ref_in = 1'b0; s0 = 2'b01; s1 = 2'b01; s2 = 2'b01;
    for (int i = 0; i < HIST; i++) hist[i] = 1'b0;
    m_mode = 0; m_tap = 8;
    repeat (4) @(posedge clk);
    #1;
    check("R10", pair_q[0], 1'b0);
    check("R10", pair_q[1], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 2'b01, 2'b01, 2'b01, "R10");

    // R3 all mid, zero skew
    wave(2'b01, 2'b01, 2'b01, 5, 40, "R3");
    // R1 open pins behave as mid
    wave(2'b11, 2'b11, 2'b11, 6, 48, "R1");
    wave(2'b01, 2'b11, 2'b01, 3, 30, "R1");
    // R4 / R2 extremes: index 5 (offset -8) and index 20 (offset +7)
    wave(2'b00, 2'b01, 2'b10, 4, 40, "R4");
    wave(2'b10, 2'b00, 2'b10, 7, 56, "R4");
    // R2 index 12 (offset -1) and index 14 (offset +1)
    wave(2'b01, 2'b01, 2'b00, 3, 30, "R2");
    wave(2'b01, 2'b01, 2'b10, 3, 30, "R2");
    // R5 pass-through, index 21
    wave(2'b10, 2'b01, 2'b00, 2, 24, "R5");
    // R6 inverted, index 22
    wave(2'b10, 2'b01, 2'b01, 5, 40, "R6");
    // R7 fallback codes index 0 and 26
    wave(2'b00, 2'b00, 2'b00, 4, 32, "R7");
    wave(2'b10, 2'b10, 2'b10, 4, 32, "R7");

    // R8: change code while reference holds steady; adoption waits for a rise
    wave(2'b01, 2'b01, 2'b01, 4, 16, "R8");
    repeat (3) step(1'b1, 2'b00, 2'b01, 2'b10, "R8");
    repeat (12) step(1'b1, 2'b10, 2'b01, 2'b00, "R8");
    repeat (12) step(1'b0, 2'b00, 2'b01, 2'b10, "R8");
    repeat (6) step(1'b0, 2'b01, 2'b01, 2'b01, "R8");
    wave(2'b00, 2'b01, 2'b10, 4, 32, "R8");

    // R4 random codes and reference patterns
    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = ($urandom % 4 == 0) ? ~hist[0] : hist[0];
      step(r, 2'($urandom), 2'($urandom), 2'($urandom), "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule